// File: doc/BRIEF.md
# Standby Wakeup Flag Controller

The block watches a set of asynchronous wakeup source lines and keeps a sticky wakeup flag that takes the chip out of its standby state. Each source line is first passed through a two-flop synchronizer. It is then gated by its own enable bit and compared with its own registered previous level. Any rising edge among the enabled sources sets the flag. Software clears the flag by pulsing a write-one-to-clear command. The history registers are never reloaded by that command, so a source that is held high during a clear does not hide a later edge on another source.

Standby can be requested in two ways. A plain request enters standby at once. A safe request runs a four-step sequence on its own: it masks every source, clears the flag, unmasks the sources and then enters standby. A busy output is raised for the whole sequence. While the block is in standby, a set flag ends the standby state on the next cycle and gives a one-cycle wake pulse to the power controller. When the flag is already set in the first standby cycle, the exit is also marked as a power-reset wakeup. This is the case when a source stayed high across the unmask step.

Top module: `wkup_flag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the flag, standby, busy, wake pulse, power-reset mark and all enable bits are 0.
- R2: A rising edge on an enabled source line sets the flag on the third clock edge after the line changes, and the flag stays set until it is cleared. An edge on a source whose enable bit is 0 leaves the flag at 0.
- R3: A one-cycle clear command drops the flag after one clock edge. If a new rising edge is seen on the same edge as the clear, the flag stays set.
- R4: When the flag is cleared while one enabled source is held high, a later rising edge on a second enabled source still sets the flag.
- R5: A source that stays high sets the flag only once: after a clear, it does not set the flag again until it falls and rises.
- R6: A plain standby request raises standby one clock edge later. If the flag is set in the first standby cycle, standby drops on the next edge, and the wake pulse and the power-reset mark are each 1 for that one cycle.
- R7: A rising edge that arrives during standby sets the flag. On the following edge standby drops and a one-cycle wake pulse is given, with the power-reset mark at 0.
- R8: A safe request holds busy high for exactly four cycles and clears the flag. Standby rises on the same edge at which busy falls.
- R9: A source that is still high when the safe sequence unmasks the sources sets the flag. The standby that follows then ends after one cycle as a power-reset wakeup.
- R10: A safe request or a plain request made while the block is in standby or while a sequence runs has no effect: busy stays 0 during standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Asynchronous wakeup source lines, active high |
| en_we_i | input | 1 | Write strobe for the enable bits |
| en_wdata_i | input | NSRC | New enable bit values, one bit per source |
| clr_flag_i | input | 1 | Write-one-to-clear command for the flag |
| stby_req_i | input | 1 | Plain standby entry request |
| safe_req_i | input | 1 | Sequenced (mask, clear, unmask, enter) standby request |
| en_o | output | NSRC | Current enable bits |
| flag_o | output | 1 | Sticky wakeup flag |
| busy_o | output | 1 | Safe entry sequence in progress |
| standby_o | output | 1 | Standby state active |
| wake_pulse_o | output | 1 | One-cycle wake pulse to the power controller |
| reset_wake_o | output | 1 | Marks a wake pulse as a power-reset wakeup |

## Verification
Two functions can fall in the same cycle. The first is a clear command, and the second is a new rising edge that sets the flag. The bench times a fresh edge on a source so that the edge detector fires on the exact edge where the clear command is sampled. Setting must win, and the flag must read 1 afterwards. The same case arises inside the safe sequence: a source that is held high across the unmask step sets the flag just before entry, and the bench expects an immediate exit marked as a power reset. A behavioural model in the bench also follows every output on every clock.

// File: rtl/wkup_pkg.sv
// Shared types for the standby wakeup flag controller.
// Assumes: one clock domain for everything after the synchronizers.
package wkup_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_MASK   = 3'd1,
        SEQ_CLEAR  = 3'd2,
        SEQ_UNMASK = 3'd3,
        SEQ_ENTER  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/wkup_sync.sv
// Two-flop synchronizer for each wakeup source line.
// Assumes: each line is quasi-static compared with the clock; no glitch filter.
module wkup_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stable_q;
        // two stages per line into the clock domain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_i[g];
                stable_q <= meta_q;
            end
        end
        assign sync_o[g] = stable_q;
    end
endmodule

// File: rtl/wkup_edge.sv
// Rising-edge detector for each gated source, with the edges ORed together.
// Assumes: the history register tracks the gated level every cycle, and a
// flag clear never touches it.
module wkup_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] en_i,
    input  logic         mask_i,
    output logic         rise_any_o
);
    logic [W-1:0] gated;
    logic [W-1:0] hist_q;
    logic [W-1:0] rise;

    for (genvar g = 0; g < W; g++) begin : g_src
        assign gated[g] = lvl_i[g] & en_i[g] & ~mask_i;
        assign rise[g]  = gated[g] & ~hist_q[g];
        // keep the last gated level of this source
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[g] <= 1'b0;
            else        hist_q[g] <= gated[g];
        end
    end

    assign rise_any_o = |rise;
endmodule

// File: rtl/wkup_seq.sv
// Safe standby entry sequencer: mask, clear, unmask, enter.
// Assumes: a request is taken only when idle and not in standby.
module wkup_seq
    import wkup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic standby_i,
    output logic mask_o,
    output logic clr_o,
    output logic enter_o,
    output logic busy_o
);
    seq_state_t state_q;
    seq_state_t state_d;

    // next step of the entry order
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (start_i && !standby_i) state_d = SEQ_MASK;
            SEQ_MASK:   state_d = SEQ_CLEAR;
            SEQ_CLEAR:  state_d = SEQ_UNMASK;
            SEQ_UNMASK: state_d = SEQ_ENTER;
            SEQ_ENTER:  state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign mask_o  = (state_q == SEQ_MASK) || (state_q == SEQ_CLEAR);
    assign clr_o   = (state_q == SEQ_CLEAR);
    assign enter_o = (state_q == SEQ_ENTER);
    assign busy_o  = (state_q != SEQ_IDLE);
endmodule

// File: rtl/wkup_flag_ctrl.sv
// Standby wakeup flag controller top: enables, sticky flag, standby state
// and wake pulse generation.
// Assumes: the requests and the clear command are single-cycle strobes in the
// clock domain; source lines may be asynchronous.
module wkup_flag_ctrl #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            en_we_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic            clr_flag_i,
    input  logic            stby_req_i,
    input  logic            safe_req_i,
    output logic [NSRC-1:0] en_o,
    output logic            flag_o,
    output logic            busy_o,
    output logic            standby_o,
    output logic            wake_pulse_o,
    output logic            reset_wake_o
);
    logic [NSRC-1:0] src_sync;
    logic [NSRC-1:0] en_q;
    logic            seq_mask;
    logic            seq_clr;
    logic            seq_enter;
    logic            rise_any;
    logic            flag_q;
    logic            stby_q;
    logic            first_q;
    logic            wake_q;
    logic            porw_q;
    logic            enter;
    logic            leave;

    wkup_sync #(.W(NSRC)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    wkup_edge #(.W(NSRC)) edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (src_sync),
        .en_i       (en_q),
        .mask_i     (seq_mask),
        .rise_any_o (rise_any)
    );

    wkup_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (safe_req_i),
        .standby_i (stby_q),
        .mask_o    (seq_mask),
        .clr_o     (seq_clr),
        .enter_o   (seq_enter),
        .busy_o    (busy_o)
    );

    assign enter = seq_enter || (stby_req_i && !busy_o && !stby_q);
    assign leave = stby_q && flag_q;

    // per-source enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= en_wdata_i;
    end

    // sticky flag: a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= 1'b0;
        else if (rise_any)                flag_q <= 1'b1;
        else if (clr_flag_i || seq_clr)   flag_q <= 1'b0;
    end

    // standby state, first-cycle mark and wake outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_q  <= 1'b0;
            first_q <= 1'b0;
            wake_q  <= 1'b0;
            porw_q  <= 1'b0;
        end else begin
            first_q <= enter;
            wake_q  <= leave;
            porw_q  <= leave && first_q;
            if (leave)      stby_q <= 1'b0;
            else if (enter) stby_q <= 1'b1;
        end
    end

    assign en_o         = en_q;
    assign flag_o       = flag_q;
    assign standby_o    = stby_q;
    assign wake_pulse_o = wake_q;
    assign reset_wake_o = porw_q;
endmodule

// File: rtl/wkup_flag_ctrl_chk.sv
// Property checker for wkup_flag_ctrl, attached with bind.
// Assumes: it sees only the ports of the top module.
module wkup_flag_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic clr_flag_i,
    input logic flag_o,
    input logic busy_o,
    input logic standby_o,
    input logic wake_pulse_o,
    input logic reset_wake_o
);
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_flag_i && !busy_o) |=> flag_o);

    assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse_o) |-> (!standby_o && $past(standby_o) && $past(flag_o)));

    assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !wake_pulse_o);

    assert_enter_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> standby_o);

    assert_por_with_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_wake_o |-> wake_pulse_o);

    assert_no_seq_in_stby_R10: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !busy_o);
endmodule

bind wkup_flag_ctrl wkup_flag_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_flag_i   (clr_flag_i),
    .flag_o       (flag_o),
    .busy_o       (busy_o),
    .standby_o    (standby_o),
    .wake_pulse_o (wake_pulse_o),
    .reset_wake_o (reset_wake_o)
);

// File: tb/wkup_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module wkup_flag_ctrl_tb_top;
    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src;
    logic            en_we;
    logic [NSRC-1:0] en_wdata;
    logic            clr;
    logic            stby_req;
    logic            safe_req;
    logic [NSRC-1:0] en_o;
    logic            flag_o, busy_o, standby_o, wake_o, por_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    wkup_flag_ctrl #(.NSRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .en_we_i(en_we),
        .en_wdata_i(en_wdata), .clr_flag_i(clr), .stby_req_i(stby_req),
        .safe_req_i(safe_req), .en_o(en_o), .flag_o(flag_o), .busy_o(busy_o),
        .standby_o(standby_o), .wake_pulse_o(wake_o), .reset_wake_o(por_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference model, advanced on every rising edge
    int m_s1[NSRC], m_s2[NSRC], m_hist[NSRC];
    int m_en[NSRC];
    int m_flag, m_stby, m_first, m_wake, m_por, m_step;
    bit m_live = 0;

    always @(posedge clk) begin
        int rise, mask, enter, leave, g;
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_hist[i] = 0; m_en[i] = 0;
            end
            m_flag = 0; m_stby = 0; m_first = 0; m_wake = 0; m_por = 0; m_step = 0;
        end else begin
            mask = (m_step == 1 || m_step == 2);
            rise = 0;
            for (int i = 0; i < NSRC; i++) begin
                g = (m_s2[i] != 0 && m_en[i] != 0 && mask == 0);
                if (g && !m_hist[i]) rise = 1;
                m_hist[i] = g;
            end
            enter = (m_step == 4) || (stby_req && m_step == 0 && !m_stby);
            leave = m_stby && m_flag;
            m_wake = leave;
            m_por = leave && m_first;
            m_first = enter;
            if (leave) m_stby = 0; else if (enter) m_stby = 1;
            if (rise) m_flag = 1; else if (clr || m_step == 2) m_flag = 0;
            if (m_step == 0) m_step = (safe_req && !m_stby) ? 1 : 0;
            else m_step = (m_step == 4) ? 0 : m_step + 1;
            for (int i = 0; i < NSRC; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = src[i];
                if (en_we) m_en[i] = en_wdata[i];
            end
        end
        m_live = 1;
    end

    // compare every output with the model between clock edges
    always @(negedge clk) begin
        if (m_live) begin
            chk("R2", "model flag", flag_o, m_flag);
            chk("R6", "model standby", standby_o, m_stby);
            chk("R8", "model busy", busy_o, m_step != 0);
            chk("R7", "model wake", wake_o, m_wake);
            chk("R9", "model por", por_o, m_por);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; src = '0; en_we = 0; en_wdata = '0; clr = 0;
        stby_req = 0; safe_req = 0;
        tick(3);
        // R1 reset state
        chk("R1", "flag", flag_o, 0);
        chk("R1", "standby", standby_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "wake", wake_o, 0);
        chk("R1", "por", por_o, 0);
        chk("R1", "enables", en_o, 0);
        rst_n = 1;
        tick(1);
        en_we = 1; en_wdata = 4'b0011;
        tick(1);
        en_we = 0;
        // R2 disabled source ignored
        src[2] = 1;
        tick(5);
        chk("R2", "disabled source flag", flag_o, 0);
        // R2 enabled source latency
        src[0] = 1;
        tick(2);
        chk("R2", "flag before sync done", flag_o, 0);
        tick(1);
        chk("R2", "flag set", flag_o, 1);
        // R3 clear, R5 held level does not re-set
        clr = 1;
        tick(1);
        clr = 0;
        chk("R3", "flag cleared", flag_o, 0);
        tick(5);
        chk("R5", "held source no re-set", flag_o, 0);
        // R4 second source edge after clear with first held high
        src[1] = 1;
        tick(3);
        chk("R4", "second source sets flag", flag_o, 1);
        // R3 set wins over clear in the same cycle
        clr = 1;
        tick(1);
        clr = 0;
        src[1] = 0;
        tick(4);
        chk("R3", "flag low before race", flag_o, 0);
        src[1] = 1;
        tick(2);
        clr = 1;
        tick(1);
        clr = 0;
        chk("R3", "set wins over clear", flag_o, 1);
        // R6 plain entry with flag already set
        stby_req = 1;
        tick(1);
        stby_req = 0;
        chk("R6", "standby entered", standby_o, 1);
        tick(1);
        chk("R6", "immediate exit", standby_o, 0);
        chk("R6", "wake pulse", wake_o, 1);
        chk("R6", "power reset mark", por_o, 1);
        tick(1);
        chk("R6", "wake pulse one cycle", wake_o, 0);
        // R7 wake by edge during standby, R10 request ignored in standby
        src = '0;
        tick(4);
        clr = 1;
        tick(1);
        clr = 0;
        stby_req = 1;
        tick(1);
        stby_req = 0;
        tick(3);
        chk("R7", "standby held", standby_o, 1);
        safe_req = 1;
        tick(1);
        safe_req = 0;
        chk("R10", "safe request ignored", busy_o, 0);
        src[1] = 1;
        tick(3);
        chk("R7", "flag during standby", flag_o, 1);
        chk("R7", "still in standby", standby_o, 1);
        tick(1);
        chk("R7", "exit", standby_o, 0);
        chk("R7", "wake pulse", wake_o, 1);
        chk("R7", "no power reset mark", por_o, 0);
        // R8 safe sequence with quiet sources
        clr = 1;
        tick(1);
        clr = 0;
        src[0] = 1;
        tick(3);
        chk("R8", "flag set before sequence", flag_o, 1);
        src = '0;
        tick(4);
        safe_req = 1;
        tick(1);
        safe_req = 0;
        stby_req = 1;
        chk("R8", "busy step 1", busy_o, 1);
        tick(1);
        stby_req = 0;
        chk("R10", "plain request ignored while busy", standby_o, 0);
        chk("R8", "busy step 2", busy_o, 1);
        tick(1);
        chk("R8", "busy step 3", busy_o, 1);
        chk("R8", "flag cleared by sequence", flag_o, 0);
        tick(1);
        chk("R8", "busy step 4", busy_o, 1);
        chk("R8", "not yet in standby", standby_o, 0);
        tick(1);
        chk("R8", "busy done", busy_o, 0);
        chk("R8", "standby at busy fall", standby_o, 1);
        chk("R8", "flag still clear", flag_o, 0);
        src[0] = 1;
        tick(4);
        chk("R7", "wake after safe entry", wake_o, 1);
        chk("R7", "normal wake mark", por_o, 0);
        // R9 source held high across the unmask step
        clr = 1;
        tick(1);
        clr = 0;
        chk("R9", "flag cleared with source high", flag_o, 0);
        tick(2);
        safe_req = 1;
        tick(1);
        safe_req = 0;
        tick(4);
        chk("R9", "standby entered", standby_o, 1);
        chk("R9", "flag set at unmask", flag_o, 1);
        tick(1);
        chk("R9", "immediate exit", standby_o, 0);
        chk("R9", "wake pulse", wake_o, 1);
        chk("R9", "power reset mark", por_o, 1);
        tick(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule